// File: doc/BRIEF.md
# Register field storage element

This block is a single configurable storage field that lives inside a control/status register. Two sides can update it. A CPU access path delivers a decoded access strobe, a read/write qualifier, write data and a per-bit write enable. Hardware delivers a next value with its load enable, set and clear requests, and a per-bit enable vector that limits which bits hardware may touch. A separate software write-enable input, active high or active low by parameter, lets hardware lock out software writes.

Parameters select the software write behaviour: plain read/write, write-one-to-clear, write-one-to-set, or clear-after-write. Other parameters select the contention winner, the polarity of the hardware enable vector and whether the field has a reset value at all. The block drives the stored value, a one-cycle access strobe, a one-cycle modify strobe and continuous AND, OR and XOR reductions of the value. Address decoding and the bus protocol are handled upstream.

Top module: `csr_field_cell`

## Requirements
- R1: With `HAS_RESET`=1 an active-low `rst_n` loads `RESET_VAL`. With `HAS_RESET`=0 a reset pulse leaves the stored value unchanged.
- R2: In read/write mode a software write replaces exactly the bits whose `sw_wbe` bit is 1. The other bits keep their value.
- R3: In write-one-to-clear mode a software write clears the bits where `sw_wdata & sw_wbe` is 1. In write-one-to-set mode it sets those bits. All other bits are unchanged.
- R4: In clear-after-write mode a software write stores its data as in R2 for one cycle. The field then reads zero from the following cycle.
- R5: A software write (`sw_req`=1, `sw_is_wr`=1) takes effect only when `sw_wr_ctl` is 1 with `SWWE_LOW`=0, or 0 with `SWWE_LOW`=1. Otherwise it leaves the value unchanged.
- R6: With `hw_we`=1 the field loads `hw_next` only on enabled bits. Enabled bits are the bits where `hw_bit_en` is 1, or where it is 0 when `HWEN_INVERT`=1.
- R7: When `hw_set` and `hw_clr` are both 1, every enabled bit ends at 1.
- R8: When an effective software update and a hardware request (`hw_we`, `hw_set` or `hw_clr`) occur in the same cycle, software wins with `HW_PRIORITY`=0 and hardware wins with `HW_PRIORITY`=1.
- R9: `acc_pulse` is 1 in exactly the cycles where `sw_req` is 1, for reads and for writes alike.
- R10: `mod_pulse` is 1 in a cycle only when an effective software write wins and changes the stored value. A read, a gated write or a write that leaves the value unchanged gives 0.
- R11: `red_and`, `red_or` and `red_xor` always equal the AND, OR and XOR reductions of `value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sw_req | input | 1 | Decoded software access strobe for this field |
| sw_is_wr | input | 1 | 1 for a write access, 0 for a read |
| sw_wdata | input | WIDTH | Software write data |
| sw_wbe | input | WIDTH | Software per-bit write enable |
| sw_wr_ctl | input | 1 | Hardware control of software writability (polarity by `SWWE_LOW`) |
| hw_next | input | WIDTH | Hardware next value |
| hw_we | input | 1 | Hardware load enable |
| hw_set | input | 1 | Hardware set of enabled bits |
| hw_clr | input | 1 | Hardware clear of enabled bits |
| hw_bit_en | input | WIDTH | Per-bit hardware enable (inverted when `HWEN_INVERT`=1) |
| value | output | WIDTH | Stored field value |
| acc_pulse | output | 1 | Software access strobe |
| mod_pulse | output | 1 | Software modify strobe |
| red_and | output | 1 | AND reduction of value |
| red_or | output | 1 | OR reduction of value |
| red_xor | output | 1 | XOR reduction of value |

## Verification
The assertions assume that `sw_req` is a decoded strobe and that every input is held stable across each rising edge. In clear-after-write mode they treat any software write in the previous cycle as still active. The bench changes inputs only on falling edges and drives them from a fixed-seed generator. Several instances with different parameter sets share the same stimulus, so every access mode, both priorities, both enable polarities and the no-reset variant see the same legal traffic.

// File: rtl/csr_field_pkg.sv
package csr_field_pkg;
   typedef enum logic [1:0] {
      SW_RW   = 2'd0,
      SW_W1C  = 2'd1,
      SW_W1S  = 2'd2,
      SW_WCLR = 2'd3
   } sw_mode_e;
endpackage

// File: rtl/csr_field_sw.sv
module csr_field_sw #(
   parameter int WIDTH = 8,
   parameter csr_field_pkg::sw_mode_e MODE = csr_field_pkg::SW_RW
) (
   input  logic [WIDTH-1:0] base,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] wbe,
   input  logic             wr,
   output logic [WIDTH-1:0] nxt
);
   logic [WIDTH-1:0] hit;
   logic [WIDTH-1:0] wr_val;

   assign hit = wdata & wbe;

   generate
      if (MODE == csr_field_pkg::SW_W1C) begin : g_w1c
         assign wr_val = base & ~hit;
      end else if (MODE == csr_field_pkg::SW_W1S) begin : g_w1s
         assign wr_val = base | hit;
      end else begin : g_load
         assign wr_val = (base & ~wbe) | hit;
      end
   endgenerate

   assign nxt = wr ? wr_val : base;
endmodule

// File: rtl/csr_field_hw.sv
module csr_field_hw #(
   parameter int WIDTH       = 8,
   parameter bit HWEN_INVERT = 1'b0
) (
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] next_val,
   input  logic [WIDTH-1:0] bit_en_raw,
   input  logic             we,
   input  logic             set,
   input  logic             clr,
   output logic [WIDTH-1:0] nxt,
   output logic             act
);
   logic [WIDTH-1:0] en;
   logic [WIDTH-1:0] loaded;
   logic [WIDTH-1:0] cleared;

   generate
      if (HWEN_INVERT) begin : g_mask
         assign en = ~bit_en_raw;
      end else begin : g_enable
         assign en = bit_en_raw;
      end
   endgenerate

   assign loaded  = we  ? ((cur & ~en) | (next_val & en)) : cur;
   assign cleared = clr ? (loaded & ~en) : loaded;
   // set is applied last so it wins over clear
   assign nxt     = set ? (cleared | en) : cleared;
   assign act     = we | set | clr;
endmodule

// File: rtl/csr_field_cell.sv
module csr_field_cell #(
   parameter int WIDTH = 8,
   parameter csr_field_pkg::sw_mode_e SW_MODE = csr_field_pkg::SW_RW,
   parameter bit HAS_RESET   = 1'b1,
   parameter logic [WIDTH-1:0] RESET_VAL = '0,
   parameter bit HW_PRIORITY = 1'b0,
   parameter bit SWWE_LOW    = 1'b0,
   parameter bit HWEN_INVERT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_req,
   input  logic             sw_is_wr,
   input  logic [WIDTH-1:0] sw_wdata,
   input  logic [WIDTH-1:0] sw_wbe,
   input  logic             sw_wr_ctl,
   input  logic [WIDTH-1:0] hw_next,
   input  logic             hw_we,
   input  logic             hw_set,
   input  logic             hw_clr,
   input  logic [WIDTH-1:0] hw_bit_en,
   output logic [WIDTH-1:0] value,
   output logic             acc_pulse,
   output logic             mod_pulse,
   output logic             red_and,
   output logic             red_or,
   output logic             red_xor
);
   localparam bit IS_WCLR = (SW_MODE == csr_field_pkg::SW_WCLR);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("csr_field_cell: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] field_q, field_d;
   logic [WIDTH-1:0] sw_base, sw_val, hw_val;
   logic             swwe_eff, sw_wr, sw_act, hw_act, sw_wins;
   logic             pend_q, pend_d;

   generate
      if (SWWE_LOW) begin : g_swwel
         assign swwe_eff = ~sw_wr_ctl;
      end else begin : g_swwe
         assign swwe_eff = sw_wr_ctl;
      end
   endgenerate

   assign sw_wr   = sw_req & sw_is_wr & swwe_eff;
   assign sw_base = pend_q ? '0 : field_q;
   assign sw_act  = sw_wr | pend_q;

   csr_field_sw #(.WIDTH(WIDTH), .MODE(SW_MODE)) u_sw (
      .base  (sw_base),
      .wdata (sw_wdata),
      .wbe   (sw_wbe),
      .wr    (sw_wr),
      .nxt   (sw_val)
   );

   csr_field_hw #(.WIDTH(WIDTH), .HWEN_INVERT(HWEN_INVERT)) u_hw (
      .cur        (field_q),
      .next_val   (hw_next),
      .bit_en_raw (hw_bit_en),
      .we         (hw_we),
      .set        (hw_set),
      .clr        (hw_clr),
      .nxt        (hw_val),
      .act        (hw_act)
   );

   assign sw_wins = ~HW_PRIORITY | ~hw_act;

   always_comb begin
      if (sw_act && sw_wins) field_d = sw_val;
      else if (hw_act)       field_d = hw_val;
      else                   field_d = field_q;
   end

   assign pend_d = IS_WCLR & sw_wr & sw_wins;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= pend_d;
   end

   generate
      if (HAS_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) field_q <= RESET_VAL;
            else        field_q <= field_d;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            field_q <= field_d;
         end
      end
   endgenerate

   assign value     = field_q;
   assign acc_pulse = sw_req;
   assign mod_pulse = sw_wr & sw_wins & (sw_val != field_q);
   assign red_and   = &field_q;
   assign red_or    = |field_q;
   assign red_xor   = ^field_q;
endmodule

// File: rtl/csr_field_chk.sv
module csr_field_chk #(
   parameter int WIDTH       = 8,
   parameter bit HW_PRIORITY = 1'b0,
   parameter bit SWWE_LOW    = 1'b0,
   parameter bit HWEN_INVERT = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sw_req,
   input logic             sw_is_wr,
   input logic             sw_wr_ctl,
   input logic             hw_we,
   input logic             hw_set,
   input logic             hw_clr,
   input logic [WIDTH-1:0] hw_bit_en,
   input logic [WIDTH-1:0] value,
   input logic             acc_pulse,
   input logic             mod_pulse,
   input logic             red_and,
   input logic             red_or,
   input logic             red_xor
);
   logic             swok, prev_swok, busy, hwany;
   logic [WIDTH-1:0] en;

   assign swok  = sw_req & sw_is_wr & (SWWE_LOW ? ~sw_wr_ctl : sw_wr_ctl);
   assign en    = HWEN_INVERT ? ~hw_bit_en : hw_bit_en;
   assign hwany = hw_we | hw_set | hw_clr;
   assign busy  = swok | prev_swok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_swok <= 1'b0;
      else        prev_swok <= swok;
   end

   assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_set && hw_clr && (HW_PRIORITY || !busy)) |=> ((value & $past(en)) == $past(en)));

   assert_mod_changes_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mod_pulse |=> (value != $past(value)));

   assert_mod_in_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mod_pulse |-> (acc_pulse && sw_is_wr));

   assert_swwe_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_req && sw_is_wr && !swok && !hwany && !prev_swok) |=> $stable(value));

   assert_hw_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_we && !hw_set && !hw_clr && !busy)
         |=> ((value & ~$past(en)) == ($past(value) & ~$past(en))));

   assert_reduce_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (value == '1) |-> (red_and && red_or));
endmodule

bind csr_field_cell csr_field_chk #(
   .WIDTH(WIDTH), .HW_PRIORITY(HW_PRIORITY), .SWWE_LOW(SWWE_LOW), .HWEN_INVERT(HWEN_INVERT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_is_wr(sw_is_wr), .sw_wr_ctl(sw_wr_ctl),
   .hw_we(hw_we), .hw_set(hw_set), .hw_clr(hw_clr), .hw_bit_en(hw_bit_en), .value(value),
   .acc_pulse(acc_pulse), .mod_pulse(mod_pulse), .red_and(red_and), .red_or(red_or),
   .red_xor(red_xor)
);

// File: tb/tb_csr_field_cell.sv
module tb_csr_field_cell;
   import csr_field_pkg::*;
   localparam int W = 8;
   localparam int N = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sw_req = 0, sw_is_wr = 0, sw_wr_ctl = 0;
   logic [W-1:0] sw_wdata = '0, sw_wbe = '0, hw_next = '0, hw_bit_en = '0;
   logic hw_we = 0, hw_set = 0, hw_clr = 0;

   always #4 clk = ~clk;

   logic [W-1:0] val [N];
   logic acc [N], mod [N], ra [N], ro [N], rx [N];

   sw_mode_e   c_mode [N] = '{SW_RW, SW_W1C, SW_W1S, SW_WCLR, SW_RW};
   bit         c_hwp  [N] = '{0, 1, 0, 0, 0};
   bit         c_swl  [N] = '{0, 0, 0, 0, 1};
   bit         c_inv  [N] = '{0, 0, 1, 0, 1};
   bit         c_rst  [N] = '{1, 1, 1, 1, 0};
   logic [W-1:0] c_rv [N] = '{8'hA5, 8'hFF, 8'h00, 8'h00, 8'h00};

   csr_field_cell #(.WIDTH(W), .SW_MODE(SW_RW), .HAS_RESET(1), .RESET_VAL(8'hA5),
      .HW_PRIORITY(0), .SWWE_LOW(0), .HWEN_INVERT(0)) dut (
      .clk, .rst_n, .sw_req, .sw_is_wr, .sw_wdata, .sw_wbe, .sw_wr_ctl, .hw_next, .hw_we,
      .hw_set, .hw_clr, .hw_bit_en, .value(val[0]), .acc_pulse(acc[0]), .mod_pulse(mod[0]),
      .red_and(ra[0]), .red_or(ro[0]), .red_xor(rx[0]));
   csr_field_cell #(.WIDTH(W), .SW_MODE(SW_W1C), .HAS_RESET(1), .RESET_VAL(8'hFF),
      .HW_PRIORITY(1), .SWWE_LOW(0), .HWEN_INVERT(0)) dut_w1c (
      .clk, .rst_n, .sw_req, .sw_is_wr, .sw_wdata, .sw_wbe, .sw_wr_ctl, .hw_next, .hw_we,
      .hw_set, .hw_clr, .hw_bit_en, .value(val[1]), .acc_pulse(acc[1]), .mod_pulse(mod[1]),
      .red_and(ra[1]), .red_or(ro[1]), .red_xor(rx[1]));
   csr_field_cell #(.WIDTH(W), .SW_MODE(SW_W1S), .HAS_RESET(1), .RESET_VAL(8'h00),
      .HW_PRIORITY(0), .SWWE_LOW(0), .HWEN_INVERT(1)) dut_w1s (
      .clk, .rst_n, .sw_req, .sw_is_wr, .sw_wdata, .sw_wbe, .sw_wr_ctl, .hw_next, .hw_we,
      .hw_set, .hw_clr, .hw_bit_en, .value(val[2]), .acc_pulse(acc[2]), .mod_pulse(mod[2]),
      .red_and(ra[2]), .red_or(ro[2]), .red_xor(rx[2]));
   csr_field_cell #(.WIDTH(W), .SW_MODE(SW_WCLR), .HAS_RESET(1), .RESET_VAL(8'h00),
      .HW_PRIORITY(0), .SWWE_LOW(0), .HWEN_INVERT(0)) dut_wclr (
      .clk, .rst_n, .sw_req, .sw_is_wr, .sw_wdata, .sw_wbe, .sw_wr_ctl, .hw_next, .hw_we,
      .hw_set, .hw_clr, .hw_bit_en, .value(val[3]), .acc_pulse(acc[3]), .mod_pulse(mod[3]),
      .red_and(ra[3]), .red_or(ro[3]), .red_xor(rx[3]));
   csr_field_cell #(.WIDTH(W), .SW_MODE(SW_RW), .HAS_RESET(0), .RESET_VAL(8'h00),
      .HW_PRIORITY(0), .SWWE_LOW(1), .HWEN_INVERT(1)) dut_nr (
      .clk, .rst_n, .sw_req, .sw_is_wr, .sw_wdata, .sw_wbe, .sw_wr_ctl, .hw_next, .hw_we,
      .hw_set, .hw_clr, .hw_bit_en, .value(val[4]), .acc_pulse(acc[4]), .mod_pulse(mod[4]),
      .red_and(ra[4]), .red_or(ro[4]), .red_xor(rx[4]));

   int checks = 0;
   int errors = 0;
   bit done = 0;
   string tag = "R1";
   logic [W-1:0] m_val [N];
   logic m_pend [N];
   bit   known [N];

   task automatic chk(input bit ok, input string req, input string what,
                      input int actual, input int expected);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, actual, expected);
      end
   endtask

   // returns {pend_next, mod, next}
   function automatic logic [W+1:0] model(input int i);
      logic eff, wr, sw_act, hw_act, wins, md;
      logic [W-1:0] base, hit, swv, hwv, en, nx;
      eff  = c_swl[i] ? ~sw_wr_ctl : sw_wr_ctl;
      wr   = sw_req & sw_is_wr & eff;
      base = (c_mode[i] == SW_WCLR && m_pend[i]) ? '0 : m_val[i];
      hit  = sw_wdata & sw_wbe;
      case (c_mode[i])
         SW_W1C:  swv = base & ~hit;
         SW_W1S:  swv = base | hit;
         default: swv = (base & ~sw_wbe) | hit;
      endcase
      if (!wr) swv = base;
      sw_act = wr | m_pend[i];
      en  = c_inv[i] ? ~hw_bit_en : hw_bit_en;
      hwv = m_val[i];
      if (hw_we)  hwv = (hwv & ~en) | (hw_next & en);
      if (hw_clr) hwv = hwv & ~en;
      if (hw_set) hwv = hwv | en;
      hw_act = hw_we | hw_set | hw_clr;
      wins = !c_hwp[i] || !hw_act;
      if (sw_act && wins) nx = swv;
      else if (hw_act)    nx = hwv;
      else                nx = m_val[i];
      md = wr && wins && (swv != m_val[i]);
      return {(c_mode[i] == SW_WCLR) && wr && wins, md, nx};
   endfunction

   task automatic step();
      logic [W+1:0] r [N];
      #1;
      for (int i = 0; i < N; i++) begin
         r[i] = model(i);
         chk(acc[i] == sw_req, "R9", $sformatf("acc[%0d]", i), acc[i], sw_req);
         if (known[i]) begin
            chk(mod[i] == r[i][W], "R10", $sformatf("mod[%0d]", i), mod[i], r[i][W]);
            chk(ra[i] == &m_val[i], "R11", $sformatf("and[%0d]", i), ra[i], &m_val[i]);
            chk(ro[i] == |m_val[i], "R11", $sformatf("or[%0d]", i), ro[i], |m_val[i]);
            chk(rx[i] == ^m_val[i], "R11", $sformatf("xor[%0d]", i), rx[i], ^m_val[i]);
         end
      end
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
         m_val[i]  = r[i][W-1:0];
         m_pend[i] = r[i][W+1];
         if (i == 4 && hw_we && !sw_req) known[4] = 1;
         if (known[i])
            chk(val[i] == m_val[i], tag, $sformatf("value[%0d]", i), val[i], m_val[i]);
      end
   endtask

   task automatic idle();
      sw_req = 0; sw_is_wr = 0; sw_wdata = '0; sw_wbe = '0; sw_wr_ctl = 0;
      hw_we = 0; hw_set = 0; hw_clr = 0; hw_next = '0; hw_bit_en = '0;
   endtask

   task automatic swop(input logic wr, input logic [W-1:0] d, input logic [W-1:0] be,
                       input logic ctl);
      sw_req = 1; sw_is_wr = wr; sw_wdata = d; sw_wbe = be; sw_wr_ctl = ctl;
   endtask

   task automatic pulse_reset();
      idle();
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      for (int i = 0; i < N; i++) begin
         m_pend[i] = 0;
         if (c_rst[i]) m_val[i] = c_rv[i];
         if (known[i])
            chk(val[i] == m_val[i], "R1", $sformatf("reset value[%0d]", i), val[i], m_val[i]);
      end
   endtask

   initial begin
      #1600000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < N; i++) begin
         m_val[i] = '0; m_pend[i] = 0; known[i] = c_rst[i];
      end
      idle();
      @(negedge clk); @(negedge clk);
      pulse_reset();                                   // R1 reset values
      tag = "R6";  hw_we = 1; hw_next = 8'h3C; hw_bit_en = 8'h00; step(); idle();
      tag = "R2";  swop(1, 8'h5A, 8'h0F, 1); step(); idle();   // R2 R3 R4 partial enables
      tag = "R4";  step();                                   // clear-after-write returns to 0
      tag = "R5";  swop(1, 8'hFF, 8'hFF, 0); step(); idle();  // gated for active-high, taken for active-low
      tag = "R5";  swop(1, 8'h00, 8'hFF, 1); step(); idle();
      tag = "R7";  hw_set = 1; hw_clr = 1; hw_bit_en = 8'hF0; step(); idle();
      tag = "R8";  swop(1, 8'h81, 8'hFF, 1); hw_we = 1; hw_next = 8'h7E; hw_bit_en = 8'hFF;
                   step(); idle();
      tag = "R6";  hw_we = 1; hw_next = 8'hFF; hw_bit_en = 8'h0C; step(); idle();
      tag = "R9";  swop(0, 8'hFF, 8'hFF, 1); step(); idle();   // read: no modify
      tag = "R10"; swop(1, val[0], 8'hFF, 1); step(); idle();  // same value rewrite
      tag = "R3";  swop(1, 8'h33, 8'hFF, 1); step(); idle();
      tag = "R8";
      for (int n = 0; n < 400; n++) begin
         sw_req    = ($urandom % 3) != 0;
         sw_is_wr  = $urandom % 2;
         sw_wdata  = W'($urandom); sw_wbe = W'($urandom);
         sw_wr_ctl = ($urandom % 4) != 0;
         hw_we  = ($urandom % 3) == 0;
         hw_set = ($urandom % 5) == 0;
         hw_clr = ($urandom % 5) == 0;
         hw_next = W'($urandom); hw_bit_en = W'($urandom);
         step();
      end
      tag = "R1";
      pulse_reset();                                   // R1 no-reset instance keeps its value
      step();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule